// File: doc/BRIEF.md
# Serial Controller Interrupt Event Generator

This block sits beside a serial (SPI) controller and turns its status signals into second-level interrupt flags. It watches three FIFO status levels: transmit idle, transmit free and receive valid. It also watches the active signals of the transmit and receive DMA buffers, and two error strobes, one for receive overrun and one for transmit underrun. Each source sets its own sticky flag bit.

A single mode input chooses how the three FIFO status sources trigger. In edge mode a flag is set only when its status rises from 0 to 1. In level mode the flag is set on every clock on which the status is high. A DMA buffer-complete flag is set when that buffer's active signal falls from 1 to 0. The two error strobes set their flags directly.

Software clears flags by writing ones through a write-one-to-clear port. The interrupt output is the OR of every flag whose enable bit is set, gated by a separate enable for the whole controller.

Top module: `spi_irq_events`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every flag bit reads 0 and `irq` is 0.
- R2: In edge mode (`level_mode`=0), a FIFO status source sets its flag once, one clock after a 0-to-1 change. A flag cleared while that source stays high remains 0. Flag bit positions: 0 is receive valid, 1 is transmit free, 2 is transmit idle.
- R3: In level mode (`level_mode`=1), a FIFO status source that is high sets its flag on every clock. A flag cleared while its source is still high therefore reads 1 again on the next cycle.
- R4: Each DMA buffer's flag is set one clock after that buffer's active signal falls from 1 to 0. A rising active signal sets nothing. Bit positions: transmit buffer A is 5 and B is 6, receive buffer A is 7 and B is 8. Bit 0 of each active bus is buffer A.
- R5: A one-cycle receive overrun strobe sets flag bit 3, and a transmit underrun strobe sets flag bit 4, one clock later.
- R6: With `clr_we`=1, each 1 in `clr_data` clears the matching flag on the next clock and each 0 leaves its flag unchanged. If a source sets a flag in the same cycle that the flag is being cleared, the flag stays 1.
- R7: `irq` is 1 exactly when `top_en` is 1 and at least one flag bit is 1 with its `irq_mask` bit also 1. The output is combinational from the flags, the mask and `top_en`.
- R8: With `clr_we`=0, the value on `clr_data` has no effect on the flags.
- R9: A DMA active signal that is already high when reset is released sets no flag until it later falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_mode | input | 1 | 1: FIFO status sources trigger on high level; 0: on rising edge |
| tx_idle | input | 1 | Transmit FIFO empty and last character shifted out |
| tx_free | input | 1 | Transmit FIFO not full |
| rx_valid | input | 1 | Receive FIFO not empty |
| tx_dma_act | input | NBUF | Transmit DMA buffer active signals, bit 0 is buffer A |
| rx_dma_act | input | NBUF | Receive DMA buffer active signals, bit 0 is buffer A |
| rx_overrun_p | input | 1 | Strobe: a character was lost while the receive FIFO was full |
| tx_underrun_p | input | 1 | Strobe: a character was sent while the transmit FIFO was empty |
| irq_mask | input | 5+2*NBUF | Per-flag interrupt enable |
| top_en | input | 1 | Controller-level interrupt enable |
| clr_we | input | 1 | Write strobe for the clear port |
| clr_data | input | 5+2*NBUF | Write-one-to-clear data |
| flags | output | 5+2*NBUF | Latched event flags |
| irq | output | 1 | Combined interrupt request |

## Verification
A FIFO status that is held high separates the two trigger modes. In edge mode it produces one flag, and a clear sticks. In level mode the flag comes back right after each clear. DMA active signals are raised and lowered to show that only the falling transition counts, and one is held high across the reset release to expose a spurious edge. Clears are issued in the same cycle as new events, clear data is presented with the write strobe low, and a long run of random inputs is compared cycle by cycle against a behavioural model, which catches mistakes in bit position, priority and masking.

// File: rtl/spi_irq_events.sv
module spi_irq_events #(
  parameter int NBUF = 2,
  localparam int W = 5 + 2 * NBUF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            level_mode,
  input  logic            tx_idle,
  input  logic            tx_free,
  input  logic            rx_valid,
  input  logic [NBUF-1:0] tx_dma_act,
  input  logic [NBUF-1:0] rx_dma_act,
  input  logic            rx_overrun_p,
  input  logic            tx_underrun_p,
  input  logic [W-1:0]    irq_mask,
  input  logic            top_en,
  input  logic            clr_we,
  input  logic [W-1:0]    clr_data,
  output logic [W-1:0]    flags,
  output logic            irq
);

  logic [2:0]      fifo_now, fifo_q, fifo_set;
  logic [2*NBUF-1:0] dma_now, dma_q, dma_set;
  logic [W-1:0]    set_vec, clr_vec;

  assign fifo_now = {tx_idle, tx_free, rx_valid};
  assign dma_now  = {rx_dma_act, tx_dma_act};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_q <= '0;
      dma_q  <= '0;
    end else begin
      fifo_q <= fifo_now;
      dma_q  <= dma_now;
    end
  end

  assign fifo_set = level_mode ? fifo_now : (fifo_now & ~fifo_q);
  assign dma_set  = dma_q & ~dma_now;

  assign set_vec = {dma_set, tx_underrun_p, rx_overrun_p, fifo_set};
  assign clr_vec = clr_we ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  assign irq = top_en & |(flags & irq_mask);

endmodule

module spi_irq_events_chk #(
  parameter int NBUF = 2,
  localparam int W = 5 + 2 * NBUF
) (
  input logic            clk,
  input logic            rst_n,
  input logic            level_mode,
  input logic            rx_valid,
  input logic [NBUF-1:0] tx_dma_act,
  input logic            rx_overrun_p,
  input logic            tx_underrun_p,
  input logic [W-1:0]    irq_mask,
  input logic            top_en,
  input logic            clr_we,
  input logic [W-1:0]    flags,
  input logic            irq
);

  a_r3_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode && rx_valid |=> flags[0]);

  a_r4_dma_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $fell(tx_dma_act[0]) |=> flags[5]);

  a_r5_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun_p |=> flags[3]);

  a_r5_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun_p |=> flags[4]);

  a_r8_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((flags & $past(flags)) == $past(flags)));

  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (top_en && ((flags & irq_mask) != '0)));

  a_r7_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    (top_en && ((flags & irq_mask) != '0)) |-> irq);

endmodule

bind spi_irq_events spi_irq_events_chk #(.NBUF(NBUF)) i_chk (
  .clk(clk), .rst_n(rst_n), .level_mode(level_mode), .rx_valid(rx_valid),
  .tx_dma_act(tx_dma_act), .rx_overrun_p(rx_overrun_p),
  .tx_underrun_p(tx_underrun_p), .irq_mask(irq_mask), .top_en(top_en),
  .clr_we(clr_we), .flags(flags), .irq(irq)
);

// File: tb/test_spi_irq_events.sv
module test_spi_irq_events;
  localparam int NB = 2;
  localparam int FW = 5 + 2 * NB;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0, level_mode = 0, tx_idle = 0, tx_free = 0, rx_valid = 0;
  logic [NB-1:0] tx_dma_act = '0, rx_dma_act = '0;
  logic rx_overrun_p = 0, tx_underrun_p = 0, top_en = 0, clr_we = 0;
  logic [FW-1:0] irq_mask = '0, clr_data = '0;
  logic [FW-1:0] flags;
  logic irq;

  spi_irq_events #(.NBUF(NB)) i_spi_irq_events (
    .clk(clk), .rst_n(rst_n), .level_mode(level_mode), .tx_idle(tx_idle),
    .tx_free(tx_free), .rx_valid(rx_valid), .tx_dma_act(tx_dma_act),
    .rx_dma_act(rx_dma_act), .rx_overrun_p(rx_overrun_p),
    .tx_underrun_p(tx_underrun_p), .irq_mask(irq_mask), .top_en(top_en),
    .clr_we(clr_we), .clr_data(clr_data), .flags(flags), .irq(irq)
  );

  int checks = 0, failures = 0, cycles = 0;
  string req = "R1";
  bit mf[FW];
  bit mp[FW];
  bit done = 0;

  function automatic bit src(int i);
    case (i)
      0: return rx_valid;
      1: return tx_free;
      2: return tx_idle;
      3: return rx_overrun_p;
      4: return tx_underrun_p;
      default: return (i < 5 + NB) ? tx_dma_act[i-5] : rx_dma_act[i-5-NB];
    endcase
  endfunction

  function automatic logic [FW-1:0] mvec();
    logic [FW-1:0] v;
    for (int i = 0; i < FW; i++) v[i] = mf[i];
    return v;
  endfunction

  task automatic model();
    for (int i = 0; i < FW; i++) begin
      bit s, hit, wipe;
      s = src(i);
      if (!rst_n) begin mf[i] = 0; mp[i] = 0; end
      else begin
        if (i < 3) hit = level_mode ? s : (s && !mp[i]);
        else if (i < 5) hit = s;
        else hit = mp[i] && !s;
        wipe = clr_we && clr_data[i];
        mf[i] = hit || (mf[i] && !wipe);
        mp[i] = s;
      end
    end
  endtask

  task automatic tick();
    logic [FW-1:0] ev;
    bit ei;
    @(posedge clk);
    model();
    #1;
    ev = mvec();
    ei = top_en && ((ev & irq_mask) != 0);
    checks++;
    if (flags !== ev || irq !== ei) begin
      failures++;
      $display("FAIL %s model: flags=%h irq=%b expected flags=%h irq=%b", req, flags, irq, ev, ei);
    end
  endtask

  task automatic chkv(string r, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_we = 1; clr_data = '1; tick(); clr_we = 0; clr_data = '0;
  endtask

  initial begin
    // R1 / R9: reset with DMA actives held high
    tx_dma_act = '1; rx_dma_act = '1;
    tick(); tick();
    chkv("R1", flags, '0); chkv("R1", {8'd0, irq}, '0);
    rst_n = 1;
    tick(); chkv("R1", flags, '0);
    tick(); tick(); chkv("R9", flags, '0);
    // R4: falling edge of transmit buffer A
    tx_dma_act[0] = 0; tick(); chkv("R4", flags, 9'h020);
    tx_dma_act[0] = 1; tick(); tick(); chkv("R4", flags, 9'h020);
    rx_dma_act[1] = 0; tick(); chkv("R4", flags, 9'h120);
    req = "R6"; clear_all(); chkv("R6", flags, '0);

    // R2: edge mode, held receive valid
    req = "R2"; level_mode = 0; rx_valid = 1; tick(); chkv("R2", flags, 9'h001);
    clr_we = 1; clr_data = 9'h001; tick(); clr_we = 0; clr_data = '0;
    tick(); tick(); chkv("R2", flags, '0);
    rx_valid = 0; tx_idle = 1; tick(); chkv("R2", flags, 9'h004);
    clear_all();

    // R3: level mode, held transmit free
    req = "R3"; level_mode = 1; tx_free = 1; tick(); chkv("R3", flags, 9'h006);
    clr_we = 1; clr_data = 9'h002; tick(); clr_we = 0; clr_data = '0;
    chkv("R3", flags, 9'h006);
    tx_free = 0; tx_idle = 0; clear_all(); tick(); chkv("R3", flags, '0);
    level_mode = 0;

    // R5: error strobes
    req = "R5"; rx_overrun_p = 1; tick(); rx_overrun_p = 0; tick(); chkv("R5", flags, 9'h008);
    tx_underrun_p = 1; tick(); tx_underrun_p = 0; chkv("R5", flags, 9'h018);

    // R6: event wins over simultaneous clear; partial clear
    req = "R6"; rx_overrun_p = 1; clr_we = 1; clr_data = 9'h008; tick();
    rx_overrun_p = 0; clr_we = 0; clr_data = '0; chkv("R6", flags, 9'h018);
    clr_we = 1; clr_data = 9'h010; tick(); clr_we = 0; clr_data = '0; chkv("R6", flags, 9'h008);

    // R8: clear data without strobe
    req = "R8"; clr_data = '1; tick(); tick(); chkv("R8", flags, 9'h008); clr_data = '0;

    // R7: masking and top-level enable
    req = "R7"; top_en = 1; irq_mask = 9'h1f7; tick(); chkv("R7", {8'd0, irq}, 9'h000);
    irq_mask = 9'h008; tick(); chkv("R7", {8'd0, irq}, 9'h001);
    top_en = 0; tick(); chkv("R7", {8'd0, irq}, 9'h000);
    top_en = 1; clear_all(); chkv("R7", {8'd0, irq}, 9'h000);

    // mixed random run against the model (R2 R3 R4 R6)
    req = "R6";
    for (int n = 0; n < 400; n++) begin
      level_mode = ($urandom % 8) == 0 ? ~level_mode : level_mode;
      {tx_idle, tx_free, rx_valid} = 3'($urandom);
      tx_dma_act = NB'($urandom); rx_dma_act = NB'($urandom);
      rx_overrun_p = ($urandom % 5) == 0; tx_underrun_p = ($urandom % 5) == 0;
      irq_mask = FW'($urandom); top_en = 1'($urandom);
      clr_we = 1'($urandom); clr_data = FW'($urandom);
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule